// File: doc/BRIEF.md
# Context-Driven Lane-Permuting Write-Back Unit

This unit drains 128-bit words from a shared bank of slot registers into a local I/O memory. A control program presents one context ID per cycle. The ID indexes a small context table, and the table entry supplies four things for that write:

- the source slot;
- a 128-bit-aligned destination line;
- a 16-bit per-byte write mask;
- an eight-lane crossbar setting that rearranges the 16-bit lanes of the word.

A context completes only when its source slot holds valid data. On completion the unit presents a permuted, masked write on the memory port. In the same cycle it pulses a consume strobe back to that slot so the slot buffer can release it. If the slot is not yet valid, the unit holds off. Nothing is written or consumed, and the control side keeps presenting the same ID until the consume strobe appears.

Before a program runs, the context table is filled through a simple load port. A table load becomes visible on the cycle after it is written. Write port outputs are combinational from the table registers and the slot inputs. Memory arbitration lies outside this unit.

Top module: `ctx_writeback`

## Requirements
- R1: While `ctx_valid` is low, `mem_we` is low and `slot_consume` is all zeros.
- R2: When `ctx_valid` is high and the selected context's source slot has `slot_valid` low, the unit stalls: `mem_we` is low and `slot_consume` is all zeros.
- R3: When `ctx_valid` is high and the source slot is valid, `slot_consume` has exactly one bit set, the bit of the context's source slot, in the same cycle as the write.
- R4: `mem_addr` equals the context's line number shifted left by 4. Its low 4 bits are always zero.
- R5: Output lane i (bits 16i+15..16i of `mem_wdata`) is source lane s, where s is bits 3i+2..3i of the context's crossbar setting. Any source lane may feed several output lanes.
- R6: `mem_be` equals the context's 16-bit byte mask, where bit b enables byte b (bits 8b+7..8b of `mem_wdata`).
- R7: A context whose byte mask is all zeros performs no write (`mem_we` low) but still consumes its source slot.
- R8: A table load with `tbl_we` high takes effect from the next cycle. A context used in the same cycle as its own reload sees the old entry.
- R9: Reset clears every table entry to slot 0, line 0, mask 0 and crossbar setting 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_valid | input | 1 | A context ID is presented this cycle |
| ctx_id | input | 4 | Context ID from the control program |
| slot_valid | input | 8 | Per-slot data valid flags |
| slot_data | input | 1024 | Slot contents, slot k at bits 128k+127..128k |
| tbl_we | input | 1 | Context table load strobe |
| tbl_idx | input | 4 | Table entry to load |
| tbl_slot | input | 3 | Source slot for the entry |
| tbl_line | input | 16 | Destination 128-bit line number |
| tbl_be | input | 16 | Byte mask for the entry |
| tbl_xbar | input | 24 | Eight 3-bit source-lane selects, lane i at bits 3i+2..3i |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 20 | Byte address, 16-byte aligned |
| mem_wdata | output | 128 | Permuted write data |
| mem_be | output | 16 | Byte enables |
| slot_consume | output | 8 | One-hot consume strobe to the slot buffer |

## Verification
The bench targets a context whose slot is invalid. A design that ignored the valid flag would write stale data and release a slot that was never filled. It drives crossbar settings that duplicate one lane everywhere and that reverse the lanes. These catch a select that is indexed backwards or that assumes a true permutation. It also covers a zero byte mask, where a wrong design would either issue an empty write or fail to consume the slot, leaving the program waiting. Finally, it reloads a table entry in the same cycle that entry is used, to confirm that the old entry is applied and that a forwarding path has not let the new one leak through.

// File: rtl/ctx_writeback.sv
module ctx_writeback #(
  parameter int NUM_SLOTS = 8,
  parameter int NUM_CTX   = 16,
  parameter int ADDR_W    = 20,
  parameter int LANES     = 8,
  parameter int LANE_W    = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               ctx_valid,
  input  logic [$clog2(NUM_CTX)-1:0]         ctx_id,
  input  logic [NUM_SLOTS-1:0]               slot_valid,
  input  logic [NUM_SLOTS*LANES*LANE_W-1:0]  slot_data,
  input  logic                               tbl_we,
  input  logic [$clog2(NUM_CTX)-1:0]         tbl_idx,
  input  logic [$clog2(NUM_SLOTS)-1:0]       tbl_slot,
  input  logic [ADDR_W-$clog2(LANES*LANE_W/8)-1:0] tbl_line,
  input  logic [LANES*LANE_W/8-1:0]          tbl_be,
  input  logic [LANES*$clog2(LANES)-1:0]     tbl_xbar,
  output logic                               mem_we,
  output logic [ADDR_W-1:0]                  mem_addr,
  output logic [LANES*LANE_W-1:0]            mem_wdata,
  output logic [LANES*LANE_W/8-1:0]          mem_be,
  output logic [NUM_SLOTS-1:0]               slot_consume
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int BYTES  = DATA_W / 8;
  localparam int OFS_W  = $clog2(BYTES);
  localparam int LINE_W = ADDR_W - OFS_W;
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int SEL_W  = $clog2(LANES);
  localparam int XB_W   = LANES * SEL_W;

  logic [SLOT_W-1:0] t_slot [NUM_CTX];
  logic [LINE_W-1:0] t_line [NUM_CTX];
  logic [BYTES-1:0]  t_be   [NUM_CTX];
  logic [XB_W-1:0]   t_xbar [NUM_CTX];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CTX; i++) begin
        t_slot[i] <= '0;
        t_line[i] <= '0;
        t_be[i]   <= '0;
        t_xbar[i] <= '0;
      end
    end else if (tbl_we) begin
      t_slot[tbl_idx] <= tbl_slot;
      t_line[tbl_idx] <= tbl_line;
      t_be[tbl_idx]   <= tbl_be;
      t_xbar[tbl_idx] <= tbl_xbar;
    end
  end

  logic [SLOT_W-1:0] cur_slot;
  logic [BYTES-1:0]  cur_be;
  logic [XB_W-1:0]   cur_xbar;
  logic [DATA_W-1:0] src_word;
  logic              fire;

  assign cur_slot = t_slot[ctx_id];
  assign cur_be   = t_be[ctx_id];
  assign cur_xbar = t_xbar[ctx_id];
  assign src_word = slot_data[cur_slot*DATA_W +: DATA_W];
  assign fire     = ctx_valid & slot_valid[cur_slot];

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      logic [SEL_W-1:0] sel;
      assign sel = cur_xbar[g*SEL_W +: SEL_W];
      assign mem_wdata[g*LANE_W +: LANE_W] = src_word[sel*LANE_W +: LANE_W];
    end
  endgenerate

  assign mem_we       = fire & (|cur_be);
  assign mem_be       = mem_we ? cur_be : '0;
  assign mem_addr     = {t_line[ctx_id], {OFS_W{1'b0}}};
  assign slot_consume = fire ? (NUM_SLOTS'(1) << cur_slot) : '0;
endmodule

module ctx_writeback_chk #(
  parameter int NUM_SLOTS = 8,
  parameter int ADDR_W    = 20,
  parameter int BYTES     = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ctx_valid,
  input logic [NUM_SLOTS-1:0] slot_valid,
  input logic                 mem_we,
  input logic [ADDR_W-1:0]    mem_addr,
  input logic [BYTES-1:0]     mem_be,
  input logic [NUM_SLOTS-1:0] slot_consume
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctx_valid |-> (!mem_we && slot_consume == '0));
  // R2
  consume_valid_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_consume & ~slot_valid) == '0);
  // R3
  write_consumes_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $countones(slot_consume) == 1);
  // R4
  aligned_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[$clog2(BYTES)-1:0] == '0);
  // R7
  no_empty_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_be != '0);
endmodule

bind ctx_writeback ctx_writeback_chk #(
  .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .BYTES(LANES*LANE_W/8)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ctx_valid(ctx_valid), .slot_valid(slot_valid),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
  .slot_consume(slot_consume)
);

// File: tb/ctx_writeback_tb.sv
module ctx_writeback_tb;
  logic          clk = 0;
  logic          rst_n;
  logic          ctx_valid;
  logic [3:0]    ctx_id;
  logic [7:0]    slot_valid;
  logic [1023:0] slot_data;
  logic          tbl_we;
  logic [3:0]    tbl_idx;
  logic [2:0]    tbl_slot;
  logic [15:0]   tbl_line;
  logic [15:0]   tbl_be;
  logic [23:0]   tbl_xbar;
  logic          mem_we;
  logic [19:0]   mem_addr;
  logic [127:0]  mem_wdata;
  logic [15:0]   mem_be;
  logic [7:0]    slot_consume;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [2:0]  m_slot [16];
  logic [15:0] m_line [16];
  logic [15:0] m_be   [16];
  logic [23:0] m_xbar [16];

  ctx_writeback u_dut (
    .clk(clk), .rst_n(rst_n), .ctx_valid(ctx_valid), .ctx_id(ctx_id),
    .slot_valid(slot_valid), .slot_data(slot_data), .tbl_we(tbl_we),
    .tbl_idx(tbl_idx), .tbl_slot(tbl_slot), .tbl_line(tbl_line),
    .tbl_be(tbl_be), .tbl_xbar(tbl_xbar), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .slot_consume(slot_consume)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  function automatic logic [127:0] permute(input logic [127:0] w, input logic [23:0] xb);
    logic [127:0] r;
    for (int i = 0; i < 8; i++) r[16*i +: 16] = w[16*xb[3*i +: 3] +: 16];
    return r;
  endfunction

  task automatic load(input int idx, input logic [2:0] s, input logic [15:0] ln,
                      input logic [15:0] be, input logic [23:0] xb);
    @(negedge clk);
    tbl_we = 1; tbl_idx = 4'(idx); tbl_slot = s; tbl_line = ln; tbl_be = be; tbl_xbar = xb;
    @(posedge clk);
    m_slot[idx] = s; m_line[idx] = ln; m_be[idx] = be; m_xbar[idx] = xb;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic fill_slots();
    for (int k = 0; k < 32; k++) slot_data[32*k +: 32] = $urandom;
  endtask

  task automatic expect_now();
    logic [2:0] s;
    logic fire;
    s = m_slot[ctx_id];
    fire = ctx_valid && slot_valid[s];
    if (!ctx_valid) begin
      check("R1 we", 128'(mem_we), 128'(0));
      check("R1 consume", 128'(slot_consume), 128'(0));
    end else if (!fire) begin
      check("R2 we", 128'(mem_we), 128'(0));
      check("R2 consume", 128'(slot_consume), 128'(0));
    end else begin
      check("R3 consume", 128'(slot_consume), 128'(8'(1) << s));
      if (m_be[ctx_id] == 0) begin
        check("R7 we", 128'(mem_we), 128'(0));
      end else begin
        check("R3 we", 128'(mem_we), 128'(1));
        check("R4 addr", 128'(mem_addr), 128'({m_line[ctx_id], 4'h0}));
        check("R5 data", mem_wdata, permute(slot_data[128*s +: 128], m_xbar[ctx_id]));
        check("R6 be", 128'(mem_be), 128'(m_be[ctx_id]));
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; ctx_valid = 0; ctx_id = 0; slot_valid = 0; slot_data = '0;
    tbl_we = 0; tbl_idx = 0; tbl_slot = 0; tbl_line = 0; tbl_be = 0; tbl_xbar = 0;
    for (int i = 0; i < 16; i++) begin
      m_slot[i] = 0; m_line[i] = 0; m_be[i] = 0; m_xbar[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    check("R1 reset we", 128'(mem_we), 128'(0));
    check("R1 reset consume", 128'(slot_consume), 128'(0));

    // R9: cleared entry consumes slot 0, no write
    @(negedge clk);
    fill_slots(); slot_valid = 8'hFF; ctx_valid = 1; ctx_id = 4'd5;
    #1;
    check("R9 consume", 128'(slot_consume), 128'(8'h01));
    check("R9 we", 128'(mem_we), 128'(0));
    @(negedge clk); ctx_valid = 0;

    // directed table
    load(0, 3'd2, 16'h0001, 16'hFFFF, {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0});
    load(1, 3'd7, 16'hABCD, 16'h00F0, {3'd0,3'd1,3'd2,3'd3,3'd4,3'd5,3'd6,3'd7});
    load(2, 3'd4, 16'hFFFF, 16'h8001, {8{3'd5}});
    load(3, 3'd1, 16'h1234, 16'h0000, 24'h123456);
    for (int i = 4; i < 16; i++)
      load(i, 3'($urandom), 16'($urandom), 16'($urandom), 24'($urandom));

    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      fill_slots(); slot_valid = 8'hFF; ctx_valid = 1; ctx_id = 4'(c);
      #1; expect_now();
    end
    // R2: stall on invalid slot
    @(negedge clk);
    slot_valid = 8'h7F; ctx_id = 4'd1;
    #1; expect_now();
    check("R2 stall", 128'(mem_we), 128'(0));

    // R8: reload entry 0 while in use
    @(negedge clk);
    slot_valid = 8'hFF; ctx_id = 4'd0;
    tbl_we = 1; tbl_idx = 4'd0; tbl_slot = 3'd6; tbl_line = 16'h0F0F; tbl_be = 16'h0FF0;
    tbl_xbar = {8{3'd1}};
    #1;
    check("R8 old addr", 128'(mem_addr), 128'(20'h00010));
    check("R8 old consume", 128'(slot_consume), 128'(8'h04));
    @(posedge clk);
    m_slot[0] = 3'd6; m_line[0] = 16'h0F0F; m_be[0] = 16'h0FF0; m_xbar[0] = {8{3'd1}};
    @(negedge clk);
    tbl_we = 0;
    #1;
    check("R8 new addr", 128'(mem_addr), 128'(20'hF0F0));
    expect_now();

    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      fill_slots();
      slot_valid = 8'($urandom);
      ctx_valid = ($urandom % 4) != 0;
      ctx_id = 4'($urandom);
      #1; expect_now();
    end

    @(negedge clk); ctx_valid = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule